// File: doc/BRIEF.md
# Exception Entry and Vector Generator

This block computes the architectural state change that takes place when a processor core takes an exception. On a single-cycle take strobe it samples the kind of exception, the faulting PC with its delay-slot information, and the current status, cause, interrupt-control and exception-base fields. One cycle later it presents the handler address, the updated exception PC registers, the cause code, the branch-delay and coprocessor fields, and the updated status bits. The core's pipeline control then writes these values back into its system registers and redirects fetch.

Handler address selection depends on several inputs. The boot-vector bit chooses between a fixed boot region and a software base. The refill flag together with the exception level decides whether a TLB miss uses the fast refill slot. Interrupts may use a dedicated offset, or a vectored offset from the highest pending unmasked line scaled by a programmable spacing. Cache errors use their own fixed slot. Non-maskable interrupt and soft reset take a separate path that targets the reset vector and records the resume address in the error PC register.

Top module: `exc_entry_gen`

## Requirements
- R1: After reset `valid_o` is 0 and `pc_o` is 0. All outputs are registered when `take_i` is high at a rising clock edge, and `valid_o` is high for exactly the one cycle after each strobe.
- R2: For a general kind, `exc_code_o` takes the value of `kind_i`. The codes are interrupt 0, TLB modify 1, TLB load 2, TLB store 3, address error load 4 and store 5, bus error instruction 6 and data 7, syscall 8, break 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, floating point 15, watch 23, machine check 24 and cache error 30. Kinds 28 (NMI) and 29 (soft reset) leave `exc_code_o` at its previous value.
- R3: The general vector base is 0xBFC0_0200 when `bev_i` is 1, and `ebase_i` with bits 9:0 cleared otherwise. The default offset is 0x180.
- R4: A TLB load or store (kind 2 or 3) with `refill_i`=1 and `exl_i`=0 uses offset 0x000. With `exl_i`=1 it uses 0x180.
- R5: An interrupt (kind 0) with `vint_i`=0 uses offset 0x200 when `iv_i`=1, and 0x180 otherwise.
- R6: With `vint_i`=1 the vector is the highest set bit among bits 7..1 of `ip_i & im_i`, or 0 if none of those bits is set. An interrupt then uses offset 0x200 + vector × (`vec_space_i` << 5).
- R7: A cache error (kind 30) uses offset 0x100 when `bev_i`=1 and 0x2000_0100 otherwise.
- R8: For a general kind with `exl_i`=0, `epc_o` is the resume PC and `bd_o` equals `in_delay_i`. In the same update `exl_o` becomes 1 and `ksu_o` becomes 0 (kernel).
- R9: For a general kind with `exl_i`=1, `epc_o`=`epc_i`, `bd_o`=`bd_i` and `ksu_o`=`ksu_i`. `exl_o` stays 1.
- R10: The resume PC is `pc_i` when `in_delay_i`=0. Otherwise it is `pc_i`−4, or `pc_i`−2 when `compact_i`=1.
- R11: NMI and soft reset behave as follows. `error_epc_o` is the resume PC, `erl_o` and `bev_o` are 1, `ksu_o` is 0 and `pc_o` is 0xBFC0_0000. `epc_o`, `bd_o` and `exl_o` pass `epc_i`, `bd_i` and `exl_i` through. NMI sets `nmi_flag_o`, and soft reset sets `sr_o`. Any flag that is not set passes its input through.
- R12: Kind 11 writes `cop_num_i` into `ce_o`. Every other kind passes `ce_i` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| take_i | input | 1 | Take-exception strobe |
| kind_i | input | 5 | Exception kind (cause code, 28 NMI, 29 soft reset) |
| refill_i | input | 1 | TLB miss had no matching entry |
| pc_i | input | 32 | Faulting PC |
| in_delay_i | input | 1 | Fault in a delay slot |
| compact_i | input | 1 | Branch uses the compact instruction size |
| cop_num_i | input | 2 | Coprocessor number for unusable fault |
| exl_i | input | 1 | Current exception level |
| erl_i | input | 1 | Current error level |
| bev_i | input | 1 | Current boot-vector bit |
| sr_i | input | 1 | Current soft-reset flag |
| nmi_flag_i | input | 1 | Current NMI flag |
| ksu_i | input | 2 | Current privilege mode |
| im_i | input | 8 | Interrupt mask |
| ip_i | input | 8 | Interrupt pending |
| iv_i | input | 1 | Dedicated interrupt vector enable |
| bd_i | input | 1 | Current branch-delay bit |
| ce_i | input | 2 | Current coprocessor field |
| vint_i | input | 1 | Vectored interrupt mode |
| vec_space_i | input | 5 | Vector spacing field |
| ebase_i | input | 32 | Exception base register |
| epc_i | input | 32 | Current EPC |
| error_epc_i | input | 32 | Current ErrorEPC |
| valid_o | output | 1 | New state valid |
| pc_o | output | 32 | Handler address |
| epc_o | output | 32 | New EPC |
| error_epc_o | output | 32 | New ErrorEPC |
| exc_code_o | output | 5 | New cause code |
| bd_o | output | 1 | New branch-delay bit |
| ce_o | output | 2 | New coprocessor field |
| exl_o | output | 1 | New exception level |
| erl_o | output | 1 | New error level |
| bev_o | output | 1 | New boot-vector bit |
| sr_o | output | 1 | New soft-reset flag |
| nmi_flag_o | output | 1 | New NMI flag |
| ksu_o | output | 2 | New privilege mode |

## Verification
The exception level acts on two functions in the same take. A refill TLB miss raised while `exl_i` is already set must fall back from the refill slot to offset 0x180, and in that same update it must also preserve `epc_i`, `bd_i` and `ksu_i` instead of recording the new fault. The bench provokes this with a TLB load strobe that has both `refill_i` and `exl_i` high. It then judges the handler address, `epc_o`, `bd_o` and `ksu_o` together, in the cycle after the strobe. A second overlap comes from an NMI that follows a general exception. The NMI must update the error path while leaving the cause code from the previous exception untouched.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned CODE_W = 5;

  typedef enum logic [CODE_W-1:0] {
    K_INT   = 5'd0,
    K_MOD   = 5'd1,
    K_TLBL  = 5'd2,
    K_TLBS  = 5'd3,
    K_ADEL  = 5'd4,
    K_ADES  = 5'd5,
    K_IBE   = 5'd6,
    K_DBE   = 5'd7,
    K_SYS   = 5'd8,
    K_BRK   = 5'd9,
    K_RI    = 5'd10,
    K_CPU   = 5'd11,
    K_OVF   = 5'd12,
    K_TRAP  = 5'd13,
    K_FPE   = 5'd15,
    K_WATCH = 5'd23,
    K_MCHK  = 5'd24,
    K_NMI   = 5'd28,
    K_SOFT  = 5'd29,
    K_CACHE = 5'd30
  } exc_kind_e;

  localparam logic [31:0] BOOT_GEN_BASE = 32'hBFC0_0200;
  localparam logic [31:0] BOOT_RST_PC   = 32'hBFC0_0000;
  localparam logic [31:0] OFF_GEN       = 32'h0000_0180;
  localparam logic [31:0] OFF_REFILL    = 32'h0000_0000;
  localparam logic [31:0] OFF_IRQ       = 32'h0000_0200;
  localparam logic [31:0] OFF_CERR_BOOT = 32'h0000_0100;
  localparam logic [31:0] OFF_CERR_RUN  = 32'h2000_0100;
endpackage

// File: rtl/exc_irq_prio.sv
module exc_irq_prio #(
  parameter int unsigned LINES = 8,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] pend_i,
  output logic [IDX_W-1:0] idx_o
);
  // line 0 never wins by itself; it yields vector 0 like "none"
  always_comb begin
    idx_o = '0;
    for (int i = 1; i < LINES; i++) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/exc_resume_calc.sv
module exc_resume_calc #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic            in_delay_i,
  input  logic            compact_i,
  output logic [XLEN-1:0] resume_o
);
  logic [XLEN-1:0] back;
  assign back     = compact_i ? XLEN'(2) : XLEN'(4);
  assign resume_o = in_delay_i ? pc_i - back : pc_i;
endmodule

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned LINES   = 8,
  parameter int unsigned SPACE_W = 5,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned STEP_W = SPACE_W + 5
) (
  input  logic [CODE_W-1:0]  kind_i,
  input  logic               refill_i,
  input  logic               exl_i,
  input  logic               bev_i,
  input  logic               iv_i,
  input  logic               vint_i,
  input  logic [IDX_W-1:0]   vec_idx_i,
  input  logic [SPACE_W-1:0] space_i,
  input  logic [XLEN-1:0]    ebase_i,
  output logic [XLEN-1:0]    target_o
);
  logic [XLEN-1:0]   base, off;
  logic [STEP_W-1:0] step;

  assign step = {space_i, 5'b0_0000};
  assign base = bev_i ? XLEN'(BOOT_GEN_BASE) : {ebase_i[XLEN-1:10], 10'b0};

  always_comb begin
    off = XLEN'(OFF_GEN);
    unique case (kind_i)
      K_INT: begin
        if (iv_i)   off = XLEN'(OFF_IRQ);
        if (vint_i) off = XLEN'(OFF_IRQ) + XLEN'(vec_idx_i) * XLEN'(step);
      end
      K_TLBL, K_TLBS: if (refill_i && !exl_i) off = XLEN'(OFF_REFILL);
      K_CACHE: off = bev_i ? XLEN'(OFF_CERR_BOOT) : XLEN'(OFF_CERR_RUN);
      default: ;
    endcase
  end

  always_comb begin
    if (kind_i == K_NMI || kind_i == K_SOFT) target_o = XLEN'(BOOT_RST_PC);
    else                                     target_o = base + off;
  end
endmodule

// File: rtl/exc_entry_gen.sv
module exc_entry_gen
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned LINES   = 8,
  parameter int unsigned SPACE_W = 5,
  localparam int unsigned IDX_W  = $clog2(LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [CODE_W-1:0]  kind_i,
  input  logic               refill_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               in_delay_i,
  input  logic               compact_i,
  input  logic [1:0]         cop_num_i,
  input  logic               exl_i,
  input  logic               erl_i,
  input  logic               bev_i,
  input  logic               sr_i,
  input  logic               nmi_flag_i,
  input  logic [1:0]         ksu_i,
  input  logic [LINES-1:0]   im_i,
  input  logic [LINES-1:0]   ip_i,
  input  logic               iv_i,
  input  logic               bd_i,
  input  logic [1:0]         ce_i,
  input  logic               vint_i,
  input  logic [SPACE_W-1:0] vec_space_i,
  input  logic [XLEN-1:0]    ebase_i,
  input  logic [XLEN-1:0]    epc_i,
  input  logic [XLEN-1:0]    error_epc_i,
  output logic               valid_o,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    error_epc_o,
  output logic [CODE_W-1:0]  exc_code_o,
  output logic               bd_o,
  output logic [1:0]         ce_o,
  output logic               exl_o,
  output logic               erl_o,
  output logic               bev_o,
  output logic               sr_o,
  output logic               nmi_flag_o,
  output logic [1:0]         ksu_o
);
  logic [IDX_W-1:0] vec_idx;
  logic [XLEN-1:0]  resume, target;
  logic             is_err, is_nmi, is_soft;

  assign is_nmi  = (kind_i == K_NMI);
  assign is_soft = (kind_i == K_SOFT);
  assign is_err  = is_nmi || is_soft;

  exc_irq_prio #(.LINES(LINES)) prio_i (
    .pend_i (ip_i & im_i),
    .idx_o  (vec_idx)
  );

  exc_resume_calc #(.XLEN(XLEN)) resume_i (
    .pc_i       (pc_i),
    .in_delay_i (in_delay_i),
    .compact_i  (compact_i),
    .resume_o   (resume)
  );

  exc_vec_sel #(.XLEN(XLEN), .LINES(LINES), .SPACE_W(SPACE_W)) vsel_i (
    .kind_i    (kind_i),
    .refill_i  (refill_i),
    .exl_i     (exl_i),
    .bev_i     (bev_i),
    .iv_i      (iv_i),
    .vint_i    (vint_i),
    .vec_idx_i (vec_idx),
    .space_i   (vec_space_i),
    .ebase_i   (ebase_i),
    .target_o  (target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      pc_o        <= '0;
      epc_o       <= '0;
      error_epc_o <= '0;
      exc_code_o  <= '0;
      bd_o        <= 1'b0;
      ce_o        <= '0;
      exl_o       <= 1'b0;
      erl_o       <= 1'b0;
      bev_o       <= 1'b0;
      sr_o        <= 1'b0;
      nmi_flag_o  <= 1'b0;
      ksu_o       <= '0;
    end else begin
      valid_o <= take_i;
      if (take_i) begin
        pc_o <= target;
        ce_o <= (kind_i == K_CPU) ? cop_num_i : ce_i;
        if (is_err) begin
          error_epc_o <= resume;
          epc_o       <= epc_i;
          bd_o        <= bd_i;
          exl_o       <= exl_i;
          erl_o       <= 1'b1;
          bev_o       <= 1'b1;
          sr_o        <= is_soft | sr_i;
          nmi_flag_o  <= is_nmi | nmi_flag_i;
          ksu_o       <= 2'b00;
        end else begin
          exc_code_o  <= kind_i;
          error_epc_o <= error_epc_i;
          epc_o       <= exl_i ? epc_i : resume;
          bd_o        <= exl_i ? bd_i : in_delay_i;
          ksu_o       <= exl_i ? ksu_i : 2'b00;
          exl_o       <= 1'b1;
          erl_o       <= erl_i;
          bev_o       <= bev_i;
          sr_o        <= sr_i;
          nmi_flag_o  <= nmi_flag_i;
        end
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        take_i,
  input logic [4:0]  kind_i,
  input logic        refill_i,
  input logic        exl_i,
  input logic        bev_i,
  input logic [31:0] ebase_i,
  input logic [31:0] epc_i,
  input logic        bd_i,
  input logic [1:0]  ksu_i,
  input logic        valid_o,
  input logic [31:0] pc_o,
  input logic [31:0] epc_o,
  input logic        bd_o,
  input logic        exl_o,
  input logic        erl_o,
  input logic        bev_o,
  input logic [1:0]  ksu_o
);
  logic special;
  assign special = (kind_i == 5'd28) || (kind_i == 5'd29);

  assert_valid_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> valid_o);
  assert_valid_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> !valid_o);
  assert_refill_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && (kind_i == 5'd2 || kind_i == 5'd3) && refill_i && !exl_i && !bev_i)
      |=> pc_o == {$past(ebase_i[31:10]), 10'b0});
  assert_enter_kernel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !special && !exl_i) |=> (exl_o && ksu_o == 2'b00));
  assert_nested_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !special && exl_i)
      |=> (epc_o == $past(epc_i) && bd_o == $past(bd_i) && ksu_o == $past(ksu_i)));
  assert_error_path_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && special) |=> (pc_o == 32'hBFC0_0000 && erl_o && bev_o));
  assert_boot_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && bev_i && kind_i == 5'd8) |=> pc_o == 32'hBFC0_0380);
endmodule

bind exc_entry_gen exc_entry_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .take_i   (take_i),
  .kind_i   (kind_i),
  .refill_i (refill_i),
  .exl_i    (exl_i),
  .bev_i    (bev_i),
  .ebase_i  (ebase_i),
  .epc_i    (epc_i),
  .bd_i     (bd_i),
  .ksu_i    (ksu_i),
  .valid_o  (valid_o),
  .pc_o     (pc_o),
  .epc_o    (epc_o),
  .bd_o     (bd_o),
  .exl_o    (exl_o),
  .erl_o    (erl_o),
  .bev_o    (bev_o),
  .ksu_o    (ksu_o)
);

// File: tb/exc_entry_gen_tb_top.sv
`timescale 1ns/1ps
module exc_entry_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        take_i = 1'b0;
  logic [4:0]  kind_i = '0;
  logic        refill_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        in_delay_i = 1'b0, compact_i = 1'b0;
  logic [1:0]  cop_num_i = '0;
  logic        exl_i = 1'b0, erl_i = 1'b0, bev_i = 1'b0, sr_i = 1'b0, nmi_flag_i = 1'b0;
  logic [1:0]  ksu_i = '0;
  logic [7:0]  im_i = '0, ip_i = '0;
  logic        iv_i = 1'b0, bd_i = 1'b0;
  logic [1:0]  ce_i = '0;
  logic        vint_i = 1'b0;
  logic [4:0]  vec_space_i = '0;
  logic [31:0] ebase_i = '0, epc_i = '0, error_epc_i = '0;
  logic        valid_o;
  logic [31:0] pc_o, epc_o, error_epc_o;
  logic [4:0]  exc_code_o;
  logic        bd_o, exl_o, erl_o, bev_o, sr_o, nmi_flag_o;
  logic [1:0]  ce_o, ksu_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  exc_entry_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take_i), .kind_i(kind_i),
    .refill_i(refill_i), .pc_i(pc_i), .in_delay_i(in_delay_i), .compact_i(compact_i),
    .cop_num_i(cop_num_i), .exl_i(exl_i), .erl_i(erl_i), .bev_i(bev_i), .sr_i(sr_i),
    .nmi_flag_i(nmi_flag_i), .ksu_i(ksu_i), .im_i(im_i), .ip_i(ip_i), .iv_i(iv_i),
    .bd_i(bd_i), .ce_i(ce_i), .vint_i(vint_i), .vec_space_i(vec_space_i),
    .ebase_i(ebase_i), .epc_i(epc_i), .error_epc_i(error_epc_i),
    .valid_o(valid_o), .pc_o(pc_o), .epc_o(epc_o), .error_epc_o(error_epc_o),
    .exc_code_o(exc_code_o), .bd_o(bd_o), .ce_o(ce_o), .exl_o(exl_o), .erl_o(erl_o),
    .bev_o(bev_o), .sr_o(sr_o), .nmi_flag_o(nmi_flag_o), .ksu_o(ksu_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic defaults();
    kind_i = 5'd8; refill_i = 0; pc_i = 32'h0000_4000; in_delay_i = 0; compact_i = 0;
    cop_num_i = 0; exl_i = 0; erl_i = 0; bev_i = 0; sr_i = 0; nmi_flag_i = 0;
    ksu_i = 2'b10; im_i = 0; ip_i = 0; iv_i = 0; bd_i = 0; ce_i = 0; vint_i = 0;
    vec_space_i = 0; ebase_i = 32'h8000_1234; epc_i = 32'h1111_0000;
    error_epc_i = 32'h2222_0000;
  endtask

  // inputs set before call at negedge; strobe one cycle; outputs checked next negedge
  task automatic fire();
    take_i = 1'b1;
    @(negedge clk_i);
    take_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset valid", {31'b0, valid_o}, 32'd0);
    chk("R1 reset pc", pc_o, 32'd0);
  endtask

  task automatic t_general();
    @(negedge clk_i); defaults();
    fire();
    chk("R1 valid after take", {31'b0, valid_o}, 32'd1);
    chk("R3 ebase+0x180", pc_o, 32'h8000_1180);
    chk("R2 syscall code", {27'b0, exc_code_o}, 32'd8);
    chk("R8 epc=pc", epc_o, 32'h0000_4000);
    chk("R8 bd", {31'b0, bd_o}, 32'd0);
    chk("R8 exl set", {31'b0, exl_o}, 32'd1);
    chk("R8 kernel", {30'b0, ksu_o}, 32'd0);
    @(negedge clk_i);
    chk("R1 valid single cycle", {31'b0, valid_o}, 32'd0);
    chk("R1 hold pc", pc_o, 32'h8000_1180);
  endtask

  task automatic t_boot_base();
    @(negedge clk_i); defaults(); bev_i = 1; kind_i = 5'd4;
    fire();
    chk("R3 boot base", pc_o, 32'hBFC0_0380);
    chk("R2 adel code", {27'b0, exc_code_o}, 32'd4);
  endtask

  task automatic t_delay();
    @(negedge clk_i); defaults(); pc_i = 32'h0000_1000; in_delay_i = 1;
    fire();
    chk("R10 delay -4", epc_o, 32'h0000_0FFC);
    chk("R8 bd set", {31'b0, bd_o}, 32'd1);
    @(negedge clk_i); defaults(); pc_i = 32'h0000_1000; in_delay_i = 1; compact_i = 1;
    fire();
    chk("R10 delay compact -2", epc_o, 32'h0000_0FFE);
  endtask

  task automatic t_refill();
    @(negedge clk_i); defaults(); kind_i = 5'd2; refill_i = 1;
    fire();
    chk("R4 refill slot", pc_o, 32'h8000_1000);
    chk("R2 tlbl code", {27'b0, exc_code_o}, 32'd2);
    // nested refill: slot demoted and EPC/bd/ksu held in the same take
    @(negedge clk_i); defaults(); kind_i = 5'd3; refill_i = 1; exl_i = 1;
    bd_i = 1; in_delay_i = 0; ksu_i = 2'b01;
    fire();
    chk("R4 nested refill 0x180", pc_o, 32'h8000_1180);
    chk("R9 epc held", epc_o, 32'h1111_0000);
    chk("R9 bd held", {31'b0, bd_o}, 32'd1);
    chk("R9 ksu held", {30'b0, ksu_o}, 32'd1);
    chk("R9 exl stays", {31'b0, exl_o}, 32'd1);
  endtask

  task automatic t_irq();
    @(negedge clk_i); defaults(); kind_i = 5'd0;
    fire();
    chk("R5 irq iv=0", pc_o, 32'h8000_1180);
    chk("R2 irq code", {27'b0, exc_code_o}, 32'd0);
    @(negedge clk_i); defaults(); kind_i = 5'd0; iv_i = 1;
    fire();
    chk("R5 irq iv=1", pc_o, 32'h8000_1200);
  endtask

  task automatic t_vectored();
    @(negedge clk_i); defaults(); kind_i = 5'd0; vint_i = 1; iv_i = 1;
    ip_i = 8'b1010_0100; im_i = 8'b0010_0110; vec_space_i = 5'd1;
    fire();
    chk("R6 vector 5 space 32", pc_o, 32'h8000_12A0);
    @(negedge clk_i); defaults(); kind_i = 5'd0; vint_i = 1;
    ip_i = 8'b0000_0001; im_i = 8'hFF; vec_space_i = 5'd4;
    fire();
    chk("R6 only line0 -> vector 0", pc_o, 32'h8000_1200);
    @(negedge clk_i); defaults(); kind_i = 5'd0; vint_i = 1;
    ip_i = 8'hFF; im_i = 8'hFF; vec_space_i = 5'd31;
    fire();
    chk("R6 vector 7 max space", pc_o, 32'h8000_2D20);
  endtask

  task automatic t_cache();
    @(negedge clk_i); defaults(); kind_i = 5'd30; bev_i = 1;
    fire();
    chk("R7 cache bev", pc_o, 32'hBFC0_0300);
    @(negedge clk_i); defaults(); kind_i = 5'd30; ebase_i = 32'h8000_0000;
    fire();
    chk("R7 cache run", pc_o, 32'hA000_0100);
    chk("R2 cache code", {27'b0, exc_code_o}, 32'd30);
  endtask

  task automatic t_cop();
    @(negedge clk_i); defaults(); kind_i = 5'd11; cop_num_i = 2'd2; ce_i = 2'd1;
    fire();
    chk("R12 ce written", {30'b0, ce_o}, 32'd2);
    chk("R2 cpu code", {27'b0, exc_code_o}, 32'd11);
    @(negedge clk_i); defaults(); kind_i = 5'd9; cop_num_i = 2'd2; ce_i = 2'd1;
    fire();
    chk("R12 ce pass", {30'b0, ce_o}, 32'd1);
  endtask

  task automatic t_error_path();
    // previous take left code 9
    @(negedge clk_i); defaults(); kind_i = 5'd28; pc_i = 32'h0000_2000; in_delay_i = 1;
    fire();
    chk("R11 nmi pc", pc_o, 32'hBFC0_0000);
    chk("R11 error epc", error_epc_o, 32'h0000_1FFC);
    chk("R11 erl", {31'b0, erl_o}, 32'd1);
    chk("R11 bev", {31'b0, bev_o}, 32'd1);
    chk("R11 nmi flag", {31'b0, nmi_flag_o}, 32'd1);
    chk("R11 sr pass", {31'b0, sr_o}, 32'd0);
    chk("R11 epc pass", epc_o, 32'h1111_0000);
    chk("R11 exl pass", {31'b0, exl_o}, 32'd0);
    chk("R11 kernel", {30'b0, ksu_o}, 32'd0);
    chk("R2 code held on nmi", {27'b0, exc_code_o}, 32'd9);
    @(negedge clk_i); defaults(); kind_i = 5'd29; exl_i = 1;
    fire();
    chk("R11 soft sr", {31'b0, sr_o}, 32'd1);
    chk("R11 soft nmi pass", {31'b0, nmi_flag_o}, 32'd0);
    chk("R11 soft error epc", error_epc_o, 32'h0000_4000);
    chk("R11 soft exl pass", {31'b0, exl_o}, 32'd1);
    chk("R2 code held on soft", {27'b0, exc_code_o}, 32'd9);
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_general();
    t_boot_base();
    t_delay();
    t_refill();
    t_irq();
    t_vectored();
    t_cache();
    t_cop();
    t_error_path();
    @(negedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule